// File: doc/BRIEF.md
# Tiled Rectangle Fill Write Coalescer

This block turns a rectangle fill on a tiled frame buffer into a short list of write bursts. After a start pulse it steps through the buffer's address space in increasing order, one pixel-sized position per cycle. For each position it recovers the pixel's column and row through a built-in reverse tile mapping and checks whether that pixel lies inside the rectangle. Positions that hit and follow one another are merged into a single burst, made of a byte start address and a byte length. Each burst is offered on a valid/ready output together with the fill colour.

The tile layout is fixed: each tile is 512 bytes wide and 8 rows tall (4096 bytes), and tiles are stored one after another in row-major order. The buffer's row pitch is given as a number of tiles per row. No address swizzle is applied. A downstream writer takes each burst and writes the colour pattern over that byte range. The scan ends as soon as every rectangle pixel has been emitted, so a small rectangle near the start of a large buffer finishes early.

Top module: `tile_fill_coalescer`

## Requirements
- R1: Positions are visited from byte 0 up to, but not including, the buffer size, advancing by the pixel size in bytes. Every burst is aligned to the pixel size and lies wholly inside the buffer.
- R2: Position p maps back to pixel coordinates as follows. Tile index t = p/4096, tile column c = t mod T and tile row r = t div T, where T is the tiles-per-row input. The column is x = (c*512 + p mod 512) / pixel bytes, and the row is y = r*8 + (p/512 mod 8).
- R3: A pixel is a hit when rect_x <= x < rect_x+rect_w and rect_y <= y < rect_y+rect_h. The union of all bursts equals exactly the set of bytes of hit pixels, and no byte is written twice.
- R4: Consecutive hit positions form one burst, and a non-hit position ends the pending burst. Each maximal hit run therefore gives ceil(run bytes / 4096) bursts.
- R5: A burst never exceeds 4096 bytes (4096/pixel-bytes pixels). A run reaching that size is emitted at once, and the next hit starts a new burst.
- R6: A run still pending at the last position of the buffer is emitted.
- R7: The block counts emitted pixels and stops scanning when the count equals rect_w*rect_h. It then raises done and holds it, with no burst pending, until the next start.
- R8: A rectangle with zero width or zero height, or a zero buffer size, reaches done without emitting any burst.
- R9: While burst_valid is high and burst_ready is low, the scan pauses, and the burst address, length and colour hold steady.
- R10: The pixel size code pix_sel selects 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits per pixel.
- R11: Each burst carries the colour latched at start. Start is accepted only while the block is not busy, and it captures all configuration inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a fill; configuration is captured on this cycle |
| rect_x | input | CW | Rectangle left column in pixels |
| rect_y | input | CW | Rectangle top row |
| rect_w | input | CW | Rectangle width in pixels |
| rect_h | input | CW | Rectangle height in rows |
| buf_size | input | AW+1 | Buffer size in bytes |
| tiles_per_row | input | AW-9 | Row pitch in 512-byte tile columns |
| pix_sel | input | 2 | Pixel size code (R10) |
| color | input | COLW | Fill colour |
| busy | output | 1 | Scan or final handoff in progress |
| done | output | 1 | Fill finished; held until next start |
| burst_valid | output | 1 | Burst offered |
| burst_ready | input | 1 | Downstream accepts the burst |
| burst_addr | output | AW | Burst byte start address |
| burst_len | output | 13 | Burst length in bytes |
| burst_color | output | COLW | Fill colour for the burst |

## Verification
On every cycle the assertions check the burst properties: the length cap, pixel alignment, containment in the buffer, stability of a stalled burst together with the paused scan, and the absence of a burst once done is set. The reverse mapping, the exact byte coverage, the number of bursts produced by coalescing, the last-position flush and the early stop can only be shown by the scenarios. In those, the bench rebuilds a byte image from the bursts and compares it with a forward per-pixel placement of the rectangle, for each pixel size, with and without backpressure.

// File: rtl/tile_fill_coalescer.sv
module tile_fill_coalescer #(
  parameter int AW   = 20,
  parameter int CW   = 14,
  parameter int COLW = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   rect_x,
  input  logic [CW-1:0]   rect_y,
  input  logic [CW-1:0]   rect_w,
  input  logic [CW-1:0]   rect_h,
  input  logic [AW:0]     buf_size,
  input  logic [AW-10:0]  tiles_per_row,
  input  logic [1:0]      pix_sel,
  input  logic [COLW-1:0] color,
  output logic            busy,
  output logic            done,
  output logic            burst_valid,
  input  logic            burst_ready,
  output logic [AW-1:0]   burst_addr,
  output logic [12:0]     burst_len,
  output logic [COLW-1:0] burst_color
);
  localparam int TCW = AW - 9;
  localparam int TRW = AW - 12;
  localparam int NW  = 2 * CW;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FLUSH, S_DONE} st_t;
  st_t st;

  logic [CW-1:0]   rx_r, ry_r, rw_r, rh_r;
  logic [AW:0]     size_r;
  logic [TCW-1:0]  tpr_r, tcol;
  logic [TRW-1:0]  trow;
  logic [1:0]      sel_r;
  logic [COLW-1:0] col_r;
  logic [AW:0]     pos;
  logic [AW-1:0]   run_start;
  logic [12:0]     run_cnt;
  logic [NW-1:0]   emitted;

  logic [3:0]      psz;
  logic [AW:0]     pos_nxt;
  logic [AW-1:0]   px, py, dx, dy;
  logic            hit, last, emit, finish, step, tile_wrap;
  logic [12:0]     cnt_new, cap;
  logic [AW-1:0]   start_new;
  logic [NW-1:0]   area, total_new;

  assign psz       = 4'd1 << sel_r;
  assign pos_nxt   = pos + (AW+1)'(psz);
  assign px        = {tcol, pos[8:0]} >> sel_r;
  assign py        = AW'({trow, pos[11:9]});
  assign dx        = px - AW'(rx_r);
  assign dy        = py - AW'(ry_r);
  assign hit       = (px >= AW'(rx_r)) && (dx < AW'(rw_r)) &&
                     (py >= AW'(ry_r)) && (dy < AW'(rh_r));
  assign cnt_new   = hit ? run_cnt + 13'd1 : run_cnt;
  assign start_new = (hit && run_cnt == 13'd0) ? pos[AW-1:0] : run_start;
  assign cap       = 13'd4096 >> sel_r;
  assign last      = pos_nxt >= size_r;
  assign emit      = (cnt_new != 13'd0) && (cnt_new == cap || !hit || last);
  assign area      = NW'(rw_r) * NW'(rh_r);
  assign total_new = emitted + (emit ? NW'(cnt_new) : '0);
  assign finish    = last || (emit && total_new == area);
  assign step      = (st == S_SCAN) && (!burst_valid || burst_ready);
  assign tile_wrap = pos_nxt[AW:12] != pos[AW:12];

  assign busy = (st == S_SCAN) || (st == S_FLUSH);
  assign done = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rx_r <= '0; ry_r <= '0; rw_r <= '0; rh_r <= '0;
      size_r <= '0; tpr_r <= '0; sel_r <= '0; col_r <= '0;
      pos <= '0; tcol <= '0; trow <= '0;
      run_start <= '0; run_cnt <= '0; emitted <= '0;
      burst_valid <= 1'b0; burst_addr <= '0; burst_len <= '0; burst_color <= '0;
    end else begin
      if (burst_valid && burst_ready) burst_valid <= 1'b0;
      case (st)
        S_IDLE, S_DONE: if (start) begin
          rx_r <= rect_x; ry_r <= rect_y; rw_r <= rect_w; rh_r <= rect_h;
          size_r <= buf_size; tpr_r <= tiles_per_row; sel_r <= pix_sel;
          col_r <= color;
          pos <= '0; tcol <= '0; trow <= '0;
          run_start <= '0; run_cnt <= '0; emitted <= '0;
          st <= (rect_w == '0 || rect_h == '0 || buf_size == '0) ? S_DONE : S_SCAN;
        end
        S_SCAN: if (step) begin
          pos       <= pos_nxt;
          run_start <= start_new;
          run_cnt   <= emit ? 13'd0 : cnt_new;
          emitted   <= total_new;
          if (tile_wrap) begin
            if (tcol == tpr_r - TCW'(1)) begin
              tcol <= '0;
              trow <= trow + TRW'(1);
            end else begin
              tcol <= tcol + TCW'(1);
            end
          end
          if (emit) begin
            burst_valid <= 1'b1;
            burst_addr  <= start_new;
            burst_len   <= cnt_new << sel_r;
            burst_color <= col_r;
          end
          if (finish) st <= emit ? S_FLUSH : S_DONE;
        end
        S_FLUSH: if (burst_ready) st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (burst_len != 13'd0 && burst_len <= 13'd4096)); // R5
  AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> ((burst_addr & AW'(psz - 4'd1)) == '0)); // R1
  AST_IN_BUFFER: assert property (@(posedge clk) disable iff (!rst_n)
    burst_valid |-> (({1'b0, burst_addr} + (AW+1)'(burst_len)) <= size_r)); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_valid && !burst_ready) |=> (burst_valid && $stable(burst_addr) &&
                                      $stable(burst_len) && $stable(burst_color))); // R9
  AST_SCAN_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SCAN && burst_valid && !burst_ready) |=> $stable(pos)); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !burst_valid); // R7
endmodule

// File: tb/tile_fill_coalescer_tb.sv
module tile_fill_coalescer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20, CW = 14, COLW = 64;
  localparam int BUF = 16384;
  localparam int TPR = 2;
  localparam int ROWS = 16;

  logic clk = 0, rst_n = 0, start = 0, burst_ready = 0;
  logic [CW-1:0] rect_x = 0, rect_y = 0, rect_w = 0, rect_h = 0;
  logic [AW:0] buf_size = BUF;
  logic [AW-10:0] tiles_per_row = TPR;
  logic [1:0] pix_sel = 0;
  logic [COLW-1:0] color = 0;
  logic busy, done, burst_valid;
  logic [AW-1:0] burst_addr;
  logic [12:0] burst_len;
  logic [COLW-1:0] burst_color;

  int checks = 0, failures = 0;
  bit exp_m [BUF];
  bit got_m [BUF];

  always #(CLK_PERIOD/2) clk = ~clk;

  tile_fill_coalescer #(.AW(AW), .CW(CW), .COLW(COLW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rect_x(rect_x), .rect_y(rect_y), .rect_w(rect_w), .rect_h(rect_h),
    .buf_size(buf_size), .tiles_per_row(tiles_per_row), .pix_sel(pix_sel),
    .color(color), .busy(busy), .done(done), .burst_valid(burst_valid),
    .burst_ready(burst_ready), .burst_addr(burst_addr), .burst_len(burst_len),
    .burst_color(burst_color));

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run_case(input int sel, input int rx, input int ry, input int rw,
                          input int rh, input int stall, input longint col);
    int psz, wpix, last_b, exp_bursts, got_bursts, cyc, run, overlap, over_cap, bad_col;
    bit finished;
    psz = 1 << sel;
    wpix = 1024 / psz;
    for (int i = 0; i < BUF; i++) begin exp_m[i] = 0; got_m[i] = 0; end
    // forward placement: tile = (y/8)*TPR + xb/512, offset (y%8)*512 + xb%512 (R2)
    for (int y = ry; y < ry + rh && y < ROWS; y++)
      for (int x = rx; x < rx + rw && x < wpix; x++) begin
        int xb, a;
        xb = x * psz;
        a = ((y / 8) * TPR + xb / 512) * 4096 + (y % 8) * 512 + xb % 512;
        for (int b = 0; b < psz; b++) exp_m[a + b] = 1;
      end
    last_b = -1; exp_bursts = 0; run = 0;
    for (int i = 0; i < BUF; i++) begin
      if (exp_m[i]) begin last_b = i; run++; end
      if ((!exp_m[i] || i == BUF - 1) && run > 0) begin
        exp_bursts += (run + 4095) / 4096;
        run = 0;
      end
    end
    @(negedge clk);
    pix_sel = sel[1:0]; rect_x = rx[CW-1:0]; rect_y = ry[CW-1:0];
    rect_w = rw[CW-1:0]; rect_h = rh[CW-1:0]; color = col; start = 1;
    @(negedge clk);
    start = 0;
    got_bursts = 0; cyc = 0; overlap = 0; over_cap = 0; bad_col = 0; finished = 0;
    while (cyc < 40000) begin
      cyc++;
      burst_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (burst_valid && burst_ready) begin
        got_bursts++;
        if (burst_len > 4096) over_cap++;
        if (burst_color != col) bad_col++;
        for (int b = 0; b < burst_len; b++) begin
          if (burst_addr + b < BUF) begin
            if (got_m[burst_addr + b]) overlap++;
            got_m[burst_addr + b] = 1;
          end else overlap++;
        end
      end
      if (done) begin finished = 1; break; end
      @(negedge clk);
    end
    chk(finished, "R7 done reached (watchdog)", cyc, 0);
    if (finished) begin
      int mism;
      mism = 0;
      for (int i = 0; i < BUF; i++) if (exp_m[i] != got_m[i]) mism++;
      chk(mism == 0, "R3 R2 coverage mismatched bytes", mism, 0);
      chk(overlap == 0, "R3 double or out-of-buffer writes", overlap, 0);
      chk(got_bursts == exp_bursts, "R4 R5 R6 burst count", got_bursts, exp_bursts);
      chk(over_cap == 0, "R5 burst over 4096 bytes", over_cap, 0);
      chk(bad_col == 0, "R11 burst colour", bad_col, 0);
      chk(!busy && !burst_valid, "R7 idle at done", busy, 0);
      if (!stall && last_b >= 0)
        chk(cyc <= last_b / psz + 4, "R7 early stop cycles", cyc, last_b / psz + 4);
      if (rw == 0 || rh == 0)
        chk(got_bursts == 0 && cyc <= 2, "R8 zero area no burst", got_bursts, 0);
      @(negedge clk);
      chk(done, "R7 done held", done, 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !burst_valid, "R11 reset state", {busy, done, burst_valid}, 0);
    rst_n = 1;
    run_case(2, 5, 3, 40, 9, 0, 64'h1111_2222_3333_4444);       // R10 32 bpp
    run_case(0, 100, 2, 700, 12, 1, 64'hA5);                    // R10 8 bpp, R9 stall
    run_case(1, 0, 0, 512, 16, 0, 64'h0BAD);                    // R5 full buffer, 16 bpp
    run_case(3, 60, 6, 10, 5, 1, 64'hDEAD_BEEF_0123_4567);      // R10 64 bpp
    run_case(2, 250, 10, 20, 20, 0, 64'h77);                    // R6 last-position flush
    run_case(2, 3, 3, 0, 5, 0, 64'h1);                          // R8 zero width
    run_case(1, 3, 3, 5, 0, 1, 64'h2);                          // R8 zero height
    run_case(0, 0, 0, 1, 1, 0, 64'h3);                          // R4 single pixel
    run_case(0, 510, 7, 4, 2, 1, 64'h4);                        // R2 tile column edge
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule